// File: doc/BRIEF.md
# SPI Master Serial Engine with Even Clock Divider

This block is the shifting core of an SPI master. It takes words from a valid/ready transmit stream and sends each one out most significant bit first on the data-out pin. At the same time it captures the data-in pin into a receive word, which it hands over through a one-word holding register with a valid/ready handshake. The serial clock is made from the core clock by a programmable divider that only divides by even values. All four clock polarity and phase combinations are supported. A three-wire option lets the single data line turn around, so that the engine listens on it instead of driving it.

Each word takes eight serial clock periods of data followed by one forced idle period. If the previous received word has not been collected when a word finishes, the engine waits with the clock at its idle level until the holding register is emptied, so no received word is ever dropped. A transfer-enable input gates all progress. When there is nothing left to send, the clock rests at its idle level and `busy` falls.

Top module: `spi_serial_engine`

## Requirements
- R1: For a divisor value D between 1 and 65535, the effective division is D rounded down to an even number, with a minimum of 2. Each SCLK level lasts half of that division in core cycles.
- R2: A divisor value of 0 divides by 65536, so each SCLK level lasts 32768 core cycles.
- R3: A word starts in the cycle after `tx_valid && tx_ready`. It then runs 8 data clock periods and one idle clock period, 18 half periods in all. With data waiting and the receive side free, the next word is accepted at the end of the idle period, with no extra core cycle in between. `tx_ready` is high only when the engine is idle, or at the last core cycle of a word's idle period.
- R4: `cpol` sets the SCLK idle level. SCLK sits at `cpol` during the idle period of every word and whenever `busy` is low.
- R5: With `cpha`=0, data in is sampled on the leading edge of each data clock, and data out changes on the trailing edge. With `cpha`=1, data out changes on the leading edge, and data in is sampled on the trailing edge.
- R6: Words are 8 bits and go out and come in MSB first. A word looped back from data-out to the sampled input is received unchanged, in both phase settings.
- R7: If `rx_valid` is still high at the end of a word's idle period, the engine holds there, with SCLK at its idle level and `busy` high. It resumes once the word has been taken. No received word is overwritten or lost, and `rx_data` stays stable while `rx_valid` is high and `rx_ready` is low.
- R8: When `three_wire` is 1 and `read_en` is 1, `mosi_oe` is 0. In three-wire mode the sampled input is `mosi_i` (the data line); otherwise it is `miso_i`.
- R9: While `active` is low, no word is accepted. A word in progress freezes: SCLK and the position within the word hold until `active` returns.
- R10: After reset `busy` is 0, `rx_valid` is 0 and SCLK equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| active | input | 1 | Transfer enable; progress only while high |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | Clock phase select |
| three_wire | input | 1 | Single bidirectional data line mode |
| read_en | input | 1 | In three-wire mode, release the data line to receive |
| divisor | input | 16 | Clock divisor (0 means 65536, odd rounded down) |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | 8 | Transmit word |
| tx_ready | output | 1 | Engine takes the transmit word this cycle |
| rx_valid | output | 1 | Received word held |
| rx_data | output | 8 | Received word |
| rx_ready | input | 1 | Consumer takes the received word |
| sclk | output | 1 | Serial clock |
| mosi_o | output | 1 | Data-out pin value |
| mosi_oe | output | 1 | Data-out pin drive enable |
| mosi_i | input | 1 | Data line readback, sampled in three-wire mode |
| miso_i | input | 1 | Serial data in, sampled in four-wire mode |
| busy | output | 1 | A word is in flight or stalled |

## Verification
A half-period counter that is off by one moves an SCLK edge by a core cycle within the first half period of a word, so it shows on `sclk` almost at once. A wrong position in the word shows on `mosi_o` in the same half period, or as a wrong `rx_data` when the word is handed over. A wrong stall decision is visible within one cycle, either as a `tx_ready` pulse while `rx_valid` is held or as `rx_data` changing under a held `rx_valid`. The bench compares every output on every cycle against a timeline model, so each such error is caught in the cycle it first appears.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;

    // Static per-transfer configuration seen by the engine.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic three_wire;
        logic read_en;
    } spi_mode_t;

    // Length of one SCLK level in core cycles for a raw divisor value.
    // Zero selects the widest division; odd values round down; 1 acts as 2.
    function automatic int unsigned half_len(input int unsigned div,
                                             input int unsigned div_w);
        int unsigned even_div;
        if (div == 0)
            even_div = 32'd1 << div_w;
        else if (div < 2)
            even_div = 2;
        else
            even_div = div & ~32'd1;
        return even_div >> 1;
    endfunction

endpackage

// File: rtl/spi_eng_divider.sv
`timescale 1ns/1ps
module spi_eng_divider
    import spi_eng_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             en,
    input  logic             hold,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_cnt;

    always_comb last_cnt = DIV_W'(half_len(32'(divisor), DIV_W) - 32'd1);

    assign tick = en && (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (en) begin
            if (tick) begin
                if (!hold)
                    cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_eng_seq.sv
`timescale 1ns/1ps
module spi_eng_seq #(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tx_valid,
    input  logic rx_full,
    input  logic tick,
    input  logic cpha,
    output logic run,
    output logic tx_ready,
    output logic load,
    output logic deliver,
    output logic stall,
    output logic sample_en,
    output logic shift_en,
    output logic sclk_phase
);
    localparam int HALVES = 2 * WORD_W + 2;
    localparam int HW     = $clog2(HALVES);
    localparam logic [HW-1:0] H_LAST    = HW'(HALVES - 1);
    localparam logic [HW-1:0] DATA_END  = HW'(2 * WORD_W);
    localparam logic [HW-1:0] SHIFT_MAX = HW'(2 * WORD_W - 2);

    logic [HW-1:0] h_q;
    logic          run_q;
    logic          in_data;
    logic          at_last;
    logic          step;

    always_comb begin
        in_data    = h_q < DATA_END;
        at_last    = run_q && (h_q == H_LAST);
        stall      = at_last && rx_full;
        step       = tick && !stall;
        deliver    = step && at_last;
        tx_ready   = active && (!run_q || (tick && at_last && !rx_full));
        load       = tx_ready && tx_valid;
        sample_en  = step && in_data && (h_q[0] == cpha);
        shift_en   = step && (h_q <= SHIFT_MAX) &&
                     (cpha ? (!h_q[0] && (h_q != '0)) : h_q[0]);
        sclk_phase = run_q && in_data && h_q[0];
    end

    assign run = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            h_q   <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            h_q   <= '0;
        end else if (deliver) begin
            run_q <= 1'b0;
            h_q   <= '0;
        end else if (step) begin
            h_q <= h_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_eng_shifter.sv
`timescale 1ns/1ps
module spi_eng_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              sample_bit,
    input  logic              deliver,
    input  logic              rx_ready,
    output logic              tx_bit,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    assign tx_bit = tx_sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst)
            tx_sh <= '0;
        else if (load)
            tx_sh <= tx_word;
        else if (shift_en)
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_sh <= '0;
        else if (sample_en)
            rx_sh <= {rx_sh[WORD_W-2:0], sample_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else if (deliver) begin
            rx_valid <= 1'b1;
            rx_word  <= rx_sh;
        end else if (rx_ready) begin
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_serial_engine.sv
`timescale 1ns/1ps
module spi_serial_engine
    import spi_eng_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              three_wire,
    input  logic              read_en,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    input  logic              rx_ready,
    output logic              sclk,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    input  logic              miso_i,
    output logic              busy
);
    spi_mode_t mode;
    logic run, tick, load, deliver, stall;
    logic sample_en, shift_en, sclk_phase, sample_bit;

    assign mode = '{cpol: cpol, cpha: cpha, three_wire: three_wire, read_en: read_en};

    spi_eng_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .en      (run && active),
        .hold    (stall),
        .divisor (divisor),
        .tick    (tick)
    );

    spi_eng_seq #(.WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .tx_valid   (tx_valid),
        .rx_full    (rx_valid),
        .tick       (tick),
        .cpha       (mode.cpha),
        .run        (run),
        .tx_ready   (tx_ready),
        .load       (load),
        .deliver    (deliver),
        .stall      (stall),
        .sample_en  (sample_en),
        .shift_en   (shift_en),
        .sclk_phase (sclk_phase)
    );

    assign sample_bit = mode.three_wire ? mosi_i : miso_i;

    spi_eng_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .tx_word    (tx_data),
        .shift_en   (shift_en),
        .sample_en  (sample_en),
        .sample_bit (sample_bit),
        .deliver    (deliver),
        .rx_ready   (rx_ready),
        .tx_bit     (mosi_o),
        .rx_valid   (rx_valid),
        .rx_word    (rx_data)
    );

    assign sclk    = mode.cpol ^ sclk_phase;
    assign mosi_oe = !(mode.three_wire && mode.read_en);
    assign busy    = run;
endmodule

// File: rtl/spi_eng_checker.sv
`timescale 1ns/1ps
module spi_eng_checker #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              active,
    input logic              cpol,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [WORD_W-1:0] rx_data,
    input logic              sclk,
    input logic              busy
);
    // R10: reset leaves the engine idle with nothing held
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !rx_valid));

    // R4: clock rests at its idle level whenever nothing is in flight
    a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cpol));

    // R7: a held received word is neither dropped nor overwritten
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R9: progress freezes while the transfer enable is low
    a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
        (busy && !active) |=> ($stable(sclk) || !$stable(cpol)));

    // R3: an accepted word puts the engine into the busy state
    a_r3_accept_starts: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> busy);
endmodule

bind spi_serial_engine spi_eng_checker #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .cpol     (cpol),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .sclk     (sclk),
    .busy     (busy)
);

// File: tb/spi_serial_engine_tb.sv
`timescale 1ns/1ps
module spi_serial_engine_tb_top;
    localparam int CLK_P   = 10;
    localparam int DIV_W   = 16;
    localparam int WORD_W  = 8;
    localparam int WD_LIM  = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic active = 1'b0, cpol = 1'b0, cpha = 1'b0, three_wire = 1'b0, read_en = 1'b0;
    logic [DIV_W-1:0] divisor = 16'd4;
    logic tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_ready, rx_valid, rx_ready = 1'b1;
    logic [7:0] rx_data;
    logic sclk, mosi_o, mosi_oe, mosi_i, miso_i, busy;

    spi_serial_engine #(.DIV_W(DIV_W), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst(rst), .active(active), .cpol(cpol), .cpha(cpha),
        .three_wire(three_wire), .read_en(read_en), .divisor(divisor),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .sclk(sclk), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_i(miso_i), .busy(busy)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] tx_q[$];
    logic [7:0] got_q[$];
    bit tx_en = 1'b1, loop_en = 1'b0, started = 1'b0;
    logic [7:0] pat = 8'h5A;
    string tag = "R1";

    assign mosi_i = loop_en ? mosi_o : pat[3];
    assign miso_i = pat[0];

    // stimulus refresh on the falling edge
    always @(negedge clk) begin
        pat      <= {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
        tx_valid <= tx_en && (tx_q.size() > 0);
        tx_data  <= (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    end

    // snapshot of settled inputs for the reference model
    logic s_rst = 1'b1, s_line, s_txv, s_act, s_rxr, s_cpha;
    logic [7:0] s_txd;
    int s_div;
    always @(negedge clk) begin
        #1;
        s_rst  = rst;
        s_line = three_wire ? mosi_i : miso_i;
        s_txv  = tx_valid;
        s_txd  = tx_data;
        s_act  = active;
        s_rxr  = rx_ready;
        s_div  = int'(divisor);
        s_cpha = cpha;
        if (rx_valid && rx_ready) got_q.push_back(rx_data);
    end

    function automatic int ref_half(int d);
        int e;
        e = (d == 0) ? 65536 : ((d < 2) ? 2 : (d - d % 2));
        return e / 2;
    endfunction

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", t, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // reference model state: timeline position inside the current word
    bit m_run = 0, m_rxv = 0;
    int m_pos = 0;
    logic [7:0] m_tx = 0, m_in = 0, m_rxd = 0;

    task automatic m_accept();
        void'(tx_q.pop_front());
        m_tx  = s_txd;
        m_run = 1;
        m_pos = 0;
    endtask

    always @(posedge clk) begin
        int hl, h, idx;
        bit was_rxv;
        bit exp_sclk;
        cyc++;
        if (cyc > WD_LIM) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIM);
            finish_run();
        end
        hl = ref_half(s_div);
        if (s_rst) begin
            m_run = 0; m_pos = 0; m_rxv = 0; m_rxd = 0; m_in = 0;
            started = 1;
        end else begin
            was_rxv = m_rxv;
            if (m_rxv && s_rxr) m_rxv = 0;
            if (!m_run) begin
                if (s_act && s_txv) m_accept();
            end else if (s_act) begin
                if (m_pos == 18 * hl - 1) begin
                    if (!was_rxv) begin
                        m_rxv = 1;
                        m_rxd = m_in;
                        if (s_txv) m_accept();
                        else begin m_run = 0; m_pos = 0; end
                    end
                end else begin
                    if (m_pos % hl == hl - 1) begin
                        h = m_pos / hl;
                        if (h < 16 && (h % 2) == int'(s_cpha))
                            m_in = {m_in[6:0], s_line};
                    end
                    m_pos++;
                end
            end
        end
        #2;
        if (started && !rst) begin
            h = m_pos / hl;
            exp_sclk = (m_run && h < 16 && (h % 2) == 1) ? !cpol : cpol;
            chk({tag, " sclk"}, 32'(sclk), 32'(exp_sclk));
            chk("R3 busy", 32'(busy), 32'(m_run));
            chk("R3 tx_ready", 32'(tx_ready),
                32'(active && (!m_run || (m_pos == 18 * hl - 1 && !m_rxv))));
            chk("R7 rx_valid", 32'(rx_valid), 32'(m_rxv));
            if (m_rxv) chk({tag, " rx_data"}, 32'(rx_data), 32'(m_rxd));
            chk("R8 mosi_oe", 32'(mosi_oe), 32'(!(three_wire && read_en)));
            if (m_run && mosi_oe) begin
                if (!cpha) idx = (h >= 14) ? 0 : 7 - h / 2;
                else idx = (h == 0) ? 7 : ((h >= 15) ? 0 : 7 - (h - 1) / 2);
                chk("R6 mosi", 32'(mosi_o), 32'(m_tx[idx]));
            end
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (tx_q.size() == 0 && !m_run && !busy) break;
        end
        cycles(3);
    endtask

    task automatic send(input logic [7:0] b);
        tx_q.push_back(b);
    endtask

    initial begin
        int base;
        cycles(4);
        rst = 1'b0;
        cycles(2);
        // R10: reset state
        chk("R10 busy after reset", 32'(busy), 0);
        chk("R10 rx_valid after reset", 32'(rx_valid), 0);
        chk("R10 sclk idle after reset", 32'(sclk), 32'(cpol));
        active = 1'b1;

        // R1: mode 0, even divisor
        tag = "R1"; divisor = 16'd4;
        send(8'hA5); send(8'h0F); send(8'hC3);
        wait_idle();

        // R5: mode 3 with odd divisor (rounded down)
        tag = "R5"; cpol = 1'b1; cpha = 1'b1; divisor = 16'd7;
        send(8'h81); send(8'h7E);
        wait_idle();

        // R4: idle high clock, phase 0, divisor 1 acts as 2
        tag = "R4"; cpha = 1'b0; divisor = 16'd1;
        cycles(2);
        chk("R4 idle level high", 32'(sclk), 1);
        send(8'h3C); send(8'hFF);
        wait_idle();

        // R5: mode 1
        tag = "R5"; cpol = 1'b0; cpha = 1'b1; divisor = 16'd2;
        send(8'h96); send(8'h00);
        wait_idle();

        // R7: receive side full stalls without loss
        tag = "R7"; cpha = 1'b0; rx_ready = 1'b0;
        base = got_q.size();
        send(8'h11); send(8'h22); send(8'h33);
        cycles(200);
        chk("R7 stalled busy", 32'(busy), 1);
        chk("R7 held valid", 32'(rx_valid), 1);
        chk("R7 clock idle in stall", 32'(sclk), 32'(cpol));
        rx_ready = 1'b1;
        wait_idle();
        chk("R7 words received", 32'(got_q.size() - base), 3);

        // R9: transfer enable gating
        tag = "R9"; divisor = 16'd6;
        send(8'h5A); send(8'hA5);
        cycles(20);
        active = 1'b0;
        cycles(50);
        chk("R9 frozen still busy", 32'(busy), 1);
        active = 1'b1;
        wait_idle();
        active = 1'b0;
        send(8'hEE);
        cycles(30);
        chk("R9 no start while disabled", 32'(busy), 0);
        active = 1'b1;
        wait_idle();

        // R8: three-wire read turnaround
        tag = "R8"; three_wire = 1'b1; read_en = 1'b1; divisor = 16'd4;
        cycles(1);
        chk("R8 line released", 32'(mosi_oe), 0);
        send(8'h00); send(8'h00);
        wait_idle();
        read_en = 1'b0;

        // R6: loopback through the data line, both phases
        tag = "R6"; loop_en = 1'b1;
        for (int ph = 0; ph < 2; ph++) begin
            cpha = ph[0];
            base = got_q.size();
            send(8'hA5); send(8'h3C); send(8'h81); send(8'h7E);
            wait_idle();
            chk("R6 loop count", 32'(got_q.size() - base), 4);
            if (got_q.size() - base == 4) begin
                chk("R6 loop word0", 32'(got_q[base]),   32'h A5);
                chk("R6 loop word1", 32'(got_q[base+1]), 32'h 3C);
                chk("R6 loop word2", 32'(got_q[base+2]), 32'h 81);
                chk("R6 loop word3", 32'(got_q[base+3]), 32'h 7E);
            end
        end
        loop_en = 1'b0; three_wire = 1'b0; cpha = 1'b0;

        // R2: divisor zero is the slowest rate
        tag = "R2"; divisor = 16'd0;
        send(8'hC0);
        cycles(3 + 32768 - 10);
        chk("R2 first half still idle", 32'(sclk), 32'(cpol));
        cycles(20);
        chk("R2 first edge reached", 32'(sclk), 32'(!cpol));
        cycles(32768);
        chk("R2 second half idle level", 32'(sclk), 32'(cpol));
        rst = 1'b1;
        tx_q.delete();
        cycles(2);
        rst = 1'b0;
        cycles(2);
        chk("R10 idle after second reset", 32'(busy), 0);
        finish_run();
    end
endmodule